// File: doc/BRIEF.md
# Stretchable External Memory Cycle Controller

This block times the external data memory accesses of a processor core. The core presents a one-cycle request carrying an address, a read/write flag and write data. The controller then runs one access cycle on the memory side. It drives an address bus with a qualifying address-phase flag, a read strobe or a write strobe, and the write data. At the end it returns read data together with a one-cycle completion pulse, and the core uses that pulse to release its stall.

A 3-bit stretch value from 0 to 7 sets how long each access lasts. It is held in a control register that is written through a small special-function-register write port at address 0x8E. Larger values lengthen every phase, which gives slower shared RAM paths (several masters contending for the same array) enough margin. Reads and writes follow different width rules. Arbitration between masters and the memory array itself lie outside this block.

Top module: `emc_ctrl`

## Requirements
- R1: The stretch register resets to 1 and is loaded from sfr_wdata_i when sfr_we_i is high with sfr_addr_i equal to 0x8E. A write to any other address leaves it unchanged. stretch_o shows its value.
- R2: A request (req_i high while the controller is idle) is taken at a clock edge, and the access phase begins in the following cycle. Throughout the phase mem_addr_vld_o is high and mem_addr_o holds the requested address.
- R3: For a read taken with stretch value s, the address phase lasts s+1 cycles and mem_rd_o is high for all of them. mem_wr_o stays low.
- R4: For a write taken with stretch value s, the address phase lasts s+2 cycles and mem_rd_o stays low.
- R5: During a write, mem_wr_o is high for 1 cycle when s is 0 and for s cycles when s is 1 to 7.
- R6: When s is 0, the write strobe occupies the first phase cycle. When s is 1 or more, it starts in the second phase cycle, which leaves one setup cycle before it and one hold cycle after it.
- R7: Read data is sampled from mem_rdata_i at the clock edge that ends the last read-strobe cycle. It is presented on rdata_o in the done cycle.
- R8: done_o is high for exactly one cycle, namely the cycle right after the last phase cycle. In that cycle the controller is idle and can take a new request.
- R9: A request raised while an access is in progress is ignored. It starts no access, and the address of the running access does not change.
- R10: A stretch write made during an access does not change that access. The new value applies from the next access on.
- R11: During a write phase, mem_wdata_o carries the requested write data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sfr_we_i | input | 1 | Control register write enable |
| sfr_addr_i | input | 8 | Control register write address |
| sfr_wdata_i | input | 3 | Stretch field of the written value |
| stretch_o | output | 3 | Current stretch setting |
| req_i | input | 1 | Access request from core |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 16 | Access address |
| req_wdata_i | input | 8 | Write data |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 8 | Captured read data |
| mem_addr_o | output | 16 | Memory address bus |
| mem_addr_vld_o | output | 1 | Address phase active |
| mem_rd_o | output | 1 | Read strobe |
| mem_wr_o | output | 1 | Write strobe |
| mem_wdata_o | output | 8 | Memory write data |
| mem_rdata_i | input | 8 | Memory read data |

## Verification
When a request is taken at edge E, the first phase cycle follows E. The done pulse and rdata_o arrive L edges later, where L is s+1 for a read and s+2 for a write. The bench drives inputs on falling edges and samples on falling edges, so it counts whole cycles of mem_addr_vld_o, mem_rd_o and mem_wr_o, together with the offset at which the write strobe starts. A scoreboard queue holds the expected stretch, address and data for each access, and these are compared when done_o appears. The bench also requires done_o to follow a phase cycle directly and to last one cycle.

// File: rtl/emc_pkg.sv
package emc_pkg;
  localparam int unsigned STRETCH_W = 3;
  localparam int unsigned STRETCH_MAX = (1 << STRETCH_W) - 1;
  localparam int unsigned CNT_W = $clog2(STRETCH_MAX + 2);

  typedef enum logic {
    OP_RD = 1'b0,
    OP_WR = 1'b1
  } op_e;

  typedef logic [STRETCH_W-1:0] stretch_t;
  typedef logic [CNT_W-1:0]     cnt_t;

  // index of final phase cycle: read s, write s+1
  function automatic cnt_t phase_last(stretch_t s, op_e op);
    cnt_t r;
    r = cnt_t'(s);
    if (op == OP_WR) r = r + cnt_t'(1);
    return r;
  endfunction
endpackage

// File: rtl/emc_stretch_reg.sv
module emc_stretch_reg
  import emc_pkg::*;
#(
  parameter int unsigned SFR_AW    = 8,
  parameter logic [SFR_AW-1:0] REG_ADDR = 8'h8E,
  parameter int unsigned RST_VAL   = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [SFR_AW-1:0] addr_i,
  input  stretch_t          wdata_i,
  output stretch_t          stretch_o
);
  localparam stretch_t RST_S = stretch_t'(RST_VAL);

  logic hit;
  assign hit = we_i && (addr_i == REG_ADDR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  stretch_o <= RST_S;
    else if (hit) stretch_o <= wdata_i;
  end
endmodule

// File: rtl/emc_seq.sv
module emc_seq
  import emc_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     start_i,
  input  op_e      op_i,
  input  stretch_t stretch_i,
  output logic     busy_o,
  output op_e      op_o,
  output stretch_t s_act_o,
  output cnt_t     cnt_o,
  output logic     last_o,
  output logic     done_o
);
  assign last_o = busy_o && (cnt_o == phase_last(s_act_o, op_o));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o  <= 1'b0;
      op_o    <= OP_RD;
      s_act_o <= '0;
      cnt_o   <= '0;
      done_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (busy_o) begin
        if (last_o) begin
          busy_o <= 1'b0;
          done_o <= 1'b1;
          cnt_o  <= '0;
        end else begin
          cnt_o <= cnt_o + cnt_t'(1);
        end
      end else if (start_i) begin
        busy_o  <= 1'b1;
        op_o    <= op_i;
        s_act_o <= stretch_i;  // frozen for the whole access
        cnt_o   <= '0;
      end
    end
  end
endmodule

// File: rtl/emc_strobe.sv
module emc_strobe
  import emc_pkg::*;
(
  input  logic     busy_i,
  input  op_e      op_i,
  input  stretch_t s_i,
  input  cnt_t     cnt_i,
  output logic     rd_o,
  output logic     wr_o
);
  logic wr_win;

  always_comb begin
    if (s_i == '0) wr_win = (cnt_i == '0);
    else           wr_win = (cnt_i != '0) && (cnt_i <= cnt_t'(s_i));
  end

  assign rd_o = busy_i && (op_i == OP_RD);
  assign wr_o = busy_i && (op_i == OP_WR) && wr_win;
endmodule

// File: rtl/emc_ctrl.sv
module emc_ctrl
  import emc_pkg::*;
#(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned SFR_AW   = 8,
  parameter logic [SFR_AW-1:0] STRETCH_ADDR = 8'h8E,
  parameter int unsigned STRETCH_RST = 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 sfr_we_i,
  input  logic [SFR_AW-1:0]    sfr_addr_i,
  input  logic [STRETCH_W-1:0] sfr_wdata_i,
  output logic [STRETCH_W-1:0] stretch_o,
  input  logic                 req_i,
  input  logic                 req_we_i,
  input  logic [ADDR_W-1:0]    req_addr_i,
  input  logic [DATA_W-1:0]    req_wdata_i,
  output logic                 done_o,
  output logic [DATA_W-1:0]    rdata_o,
  output logic [ADDR_W-1:0]    mem_addr_o,
  output logic                 mem_addr_vld_o,
  output logic                 mem_rd_o,
  output logic                 mem_wr_o,
  output logic [DATA_W-1:0]    mem_wdata_o,
  input  logic [DATA_W-1:0]    mem_rdata_i
);
  stretch_t s_cfg, s_act;
  op_e      op_req, op_act;
  cnt_t     cnt;
  logic     busy, last, start;

  assign op_req = req_we_i ? OP_WR : OP_RD;
  assign start  = req_i && !busy;

  emc_stretch_reg #(
    .SFR_AW  (SFR_AW),
    .REG_ADDR(STRETCH_ADDR),
    .RST_VAL (STRETCH_RST)
  ) u_sreg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (sfr_we_i),
    .addr_i   (sfr_addr_i),
    .wdata_i  (sfr_wdata_i),
    .stretch_o(s_cfg)
  );

  emc_seq u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start),
    .op_i     (op_req),
    .stretch_i(s_cfg),
    .busy_o   (busy),
    .op_o     (op_act),
    .s_act_o  (s_act),
    .cnt_o    (cnt),
    .last_o   (last),
    .done_o   (done_o)
  );

  emc_strobe u_strb (
    .busy_i(busy),
    .op_i  (op_act),
    .s_i   (s_act),
    .cnt_i (cnt),
    .rd_o  (mem_rd_o),
    .wr_o  (mem_wr_o)
  );

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (start) begin
      addr_q  <= req_addr_i;
      wdata_q <= req_wdata_i;
    end
  end

  // sample at the edge closing the final read-strobe cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        rdata_q <= '0;
    else if (last && op_act == OP_RD)   rdata_q <= mem_rdata_i;
  end

  assign stretch_o      = s_cfg;
  assign mem_addr_vld_o = busy;
  assign mem_addr_o     = addr_q;
  assign mem_wdata_o    = wdata_q;
  assign rdata_o        = rdata_q;
endmodule

// File: rtl/emc_ctrl_checker.sv
module emc_ctrl_checker
  import emc_pkg::*;
#(
  parameter int unsigned ADDR_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              done_o,
  input logic              mem_addr_vld_o,
  input logic              mem_rd_o,
  input logic              mem_wr_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input stretch_t          s_act
);
  a_r8_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r8_done_after_phase: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!mem_addr_vld_o && $past(mem_addr_vld_o)));

  a_r3_strobe_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_rd_o && mem_wr_o));

  a_r5_wr_in_phase: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_o |-> mem_addr_vld_o);

  a_r3_rd_in_phase: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |-> mem_addr_vld_o);

  a_r9_addr_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_addr_vld_o && $past(mem_addr_vld_o)) |-> $stable(mem_addr_o));

  a_r10_stretch_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_addr_vld_o && $past(mem_addr_vld_o)) |-> $stable(s_act));

  a_r6_wr_setup: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(mem_addr_vld_o) && mem_wr_o) |-> (s_act == '0));
endmodule

bind emc_ctrl emc_ctrl_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .done_o        (done_o),
  .mem_addr_vld_o(mem_addr_vld_o),
  .mem_rd_o      (mem_rd_o),
  .mem_wr_o      (mem_wr_o),
  .mem_addr_o    (mem_addr_o),
  .s_act         (s_act)
);

// File: tb/emc_ctrl_test.sv
module emc_ctrl_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sfr_we_i = 1'b0;
  logic [7:0]  sfr_addr_i = '0;
  logic [2:0]  sfr_wdata_i = '0;
  logic [2:0]  stretch_o;
  logic        req_i = 1'b0, req_we_i = 1'b0;
  logic [15:0] req_addr_i = '0;
  logic [7:0]  req_wdata_i = '0;
  logic        done_o;
  logic [7:0]  rdata_o;
  logic [15:0] mem_addr_o;
  logic        mem_addr_vld_o, mem_rd_o, mem_wr_o;
  logic [7:0]  mem_wdata_o, mem_rdata_i;

  always #4 clk_i = ~clk_i;

  function automatic logic [7:0] mem_val(logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction
  assign mem_rdata_i = mem_rd_o ? mem_val(mem_addr_o) : 8'h00;

  emc_ctrl uut (.*);

  typedef struct {
    bit          we;
    logic [15:0] addr;
    logic [7:0]  data;
    int          s;
  } exp_t;
  exp_t q[$];

  int checks = 0, failures = 0, issued = 0, phases = 0;
  int cur_s = 1;
  bit finished = 1'b0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // monitor
  int len, rdc, wrc, wroff;
  logic [15:0] a0;
  logic [7:0]  wd;
  bit addr_bad, prev_busy, prev_done;
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (mem_addr_vld_o) begin
        if (!prev_busy) begin
          phases++;
          len = 0; rdc = 0; wrc = 0; wroff = -1;
          a0 = mem_addr_o; addr_bad = 1'b0; wd = 8'h00;
        end
        if (mem_addr_o !== a0) addr_bad = 1'b1;
        if (mem_rd_o) rdc++;
        if (mem_wr_o) begin
          if (wroff < 0) wroff = len;
          wrc++;
          wd = mem_wdata_o;
        end
        len++;
      end
      if (done_o) begin
        chk(prev_busy && !mem_addr_vld_o, "R8", "done placement", int'(prev_busy), 1);
        chk(!prev_done, "R8", "done width", int'(prev_done), 0);
        if (q.size() == 0) begin
          chk(1'b0, "R9", "unexpected access", 1, 0);
        end else begin
          exp_t e;
          e = q.pop_front();
          chk(a0 == e.addr && !addr_bad, "R2", "address", int'(a0), int'(e.addr));
          if (e.we) begin
            chk(len == e.s + 2, "R4", "write phase len", len, e.s + 2);
            chk(rdc == 0, "R4", "rd during write", rdc, 0);
            chk(wrc == ((e.s == 0) ? 1 : e.s), "R5", "wr width", wrc, (e.s == 0) ? 1 : e.s);
            chk(wroff == ((e.s == 0) ? 0 : 1), "R6", "wr offset", wroff, (e.s == 0) ? 0 : 1);
            chk(wd == e.data, "R11", "wdata", int'(wd), int'(e.data));
          end else begin
            chk(len == e.s + 1, "R3", "read phase len", len, e.s + 1);
            chk(rdc == e.s + 1, "R3", "rd width", rdc, e.s + 1);
            chk(wrc == 0, "R3", "wr during read", wrc, 0);
            chk(rdata_o == mem_val(e.addr), "R7", "rdata", int'(rdata_o), int'(mem_val(e.addr)));
          end
        end
      end
      prev_busy = mem_addr_vld_o;
      prev_done = done_o;
    end
  end

  task automatic issue(bit we, logic [15:0] a, logic [7:0] d);
    exp_t e;
    @(negedge clk_i);
    while (mem_addr_vld_o) @(negedge clk_i);
    req_i = 1'b1; req_we_i = we; req_addr_i = a; req_wdata_i = d;
    e.we = we; e.addr = a; e.data = d; e.s = cur_s;
    q.push_back(e);
    issued++;
    @(negedge clk_i);
    req_i = 1'b0;
  endtask

  task automatic wait_done();
    do @(negedge clk_i); while (!done_o);
  endtask

  task automatic sfr_wr(logic [7:0] a, logic [2:0] d);
    @(negedge clk_i);
    sfr_we_i = 1'b1; sfr_addr_i = a; sfr_wdata_i = d;
    @(negedge clk_i);
    sfr_we_i = 1'b0;
    if (a == 8'h8E) cur_s = int'(d);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    checks++; failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(stretch_o == 3'd1, "R1", "reset stretch", int'(stretch_o), 1);
    chk(!mem_addr_vld_o && !mem_rd_o && !mem_wr_o && !done_o, "R2", "idle outputs", 0, 0);

    issue(1'b0, 16'h1234, 8'h00); wait_done();
    issue(1'b1, 16'h0042, 8'h9C); wait_done();

    sfr_wr(8'h8F, 3'd6);
    @(negedge clk_i);
    chk(stretch_o == 3'd1, "R1", "other address ignored", int'(stretch_o), 1);

    for (int s = 0; s < 8; s++) begin
      sfr_wr(8'h8E, 3'(s));
      @(negedge clk_i);
      chk(stretch_o == 3'(s), "R1", "stretch write", int'(stretch_o), s);
      issue(1'b0, 16'h0100 * s + 16'h0033, 8'h00); wait_done();
      issue(1'b1, 16'hA000 + 16'(s), 8'(8'h11 * s + 8'h07)); wait_done();
    end

    // R9: request during a running access is ignored
    sfr_wr(8'h8E, 3'd7);
    issue(1'b0, 16'h0F0F, 8'h00);
    req_i = 1'b1; req_we_i = 1'b1; req_addr_i = 16'hDEAD; req_wdata_i = 8'hEE;
    repeat (3) @(negedge clk_i);
    req_i = 1'b0;
    wait_done();
    @(negedge clk_i);
    chk(phases == issued, "R9", "access count", phases, issued);

    // R10: stretch write during an access applies to the next one
    sfr_wr(8'h8E, 3'd2);
    issue(1'b0, 16'h2222, 8'h00);
    sfr_wr(8'h8E, 3'd5);
    q[0].s = 2;
    wait_done();
    chk(stretch_o == 3'd5, "R10", "new stretch held", int'(stretch_o), 5);
    issue(1'b1, 16'h3333, 8'h5C); wait_done();

    // R8: back-to-back, new request taken in the done cycle
    sfr_wr(8'h8E, 3'd0);
    issue(1'b0, 16'h4444, 8'h00);
    wait_done();
    req_i = 1'b1; req_we_i = 1'b1; req_addr_i = 16'h5555; req_wdata_i = 8'hA3;
    begin
      exp_t e;
      e.we = 1'b1; e.addr = 16'h5555; e.data = 8'hA3; e.s = 0;
      q.push_back(e); issued++;
    end
    @(negedge clk_i);
    req_i = 1'b0;
    chk(mem_addr_vld_o == 1'b1, "R8", "accept in done cycle", int'(mem_addr_vld_o), 1);
    wait_done();

    repeat (3) @(negedge clk_i);
    chk(q.size() == 0, "R2", "scoreboard drained", q.size(), 0);
    chk(phases == issued, "R9", "final access count", phases, issued);
    finish_run();
  end
endmodule